// File: doc/BRIEF.md
# Serial Port Ownership and Interrupt Front End

This block is the register front end of a serial port. It decodes two host registers, a configuration register and a data register, and it decides who drives the UART byte streams: the host through the data register, or an internal packet-framing engine. After reset the host owns the port. Setting the handover bit in the configuration register passes both byte streams to the engine. The switch waits until the transmitter is idle, so a byte is never half sent from one source and finished from the other.

The block also produces the host interrupt. Two level-sensitive sources, receive data available and transmit drained, are each masked by their own enable bit and then ORed. While the engine owns the port the interrupt stays low. The host data register is then inert: a write to it is dropped and a read of it returns zero.

The configuration register sits at address 0x08. Its fields are bit 0 software RTS level, bit 1 receive interrupt enable, bit 2 transmit interrupt enable, bit 5 hardware flow control enable and bit 7 handover request. On a read, bit 6 returns the current owner (1 means the engine) and the bits not listed return 0. The data register sits at address 0x0A.

Top module: `sport_owner_ctrl`

## Requirements
- R1: After reset, owner_eng_o, flow_en_o, rx_ie_o, tx_ie_o, rts_o and irq_o are all 0.
- R2: A write to address 0x08 stores bits 0, 1, 2, 5 and 7 and ignores the rest. A read of 0x08 returns, one cycle later on host_rdata_o, those stored bits, bit 6 = current owner, and 0 in bits 3 and 4.
- R3: With flow control off (bit 5 = 0), rts_o follows stored bit 0. With flow control on, rts_o = !rx_half_i.
- R4: While the host owns the port, a host write to 0x0A pulses tx_push_o in the same cycle with tx_byte_o = host_wdata_i, provided tx_full_i = 0. When tx_full_i = 1 there is no push.
- R5: While the host owns the port, a host read of 0x0A with rx_empty_i = 0 pulses rx_pop_o in the same cycle, and host_rdata_o carries rx_byte_i one cycle later. With rx_empty_i = 1 there is no pop and the read returns 0.
- R6: owner_eng_o takes the stored handover bit one cycle after a clock edge at which the two differ and the transmitter is idle (tx_empty_i = 1 and tx_busy_i = 0). Otherwise it holds.
- R7: While the engine owns the port, tx_push_o = eng_tx_valid_i & eng_tx_ready_o, tx_byte_o = eng_tx_byte_i, eng_tx_ready_o = !tx_full_i, eng_rx_valid_o = !rx_empty_i and rx_pop_o = eng_rx_valid_o & eng_rx_ready_i. While the host owns it, eng_tx_ready_o and eng_rx_valid_o are 0.
- R8: While the engine owns the port, a host write to 0x0A pushes nothing, and a host read of 0x0A pops nothing and returns 0.
- R9: irq_o is 1 one cycle after an edge at which the host owns the port, rx_ie_o = 1 and rx_empty_i = 0. It stays 1 until the FIFO reports empty.
- R10: irq_o is 1 one cycle after an edge at which the host owns the port, tx_ie_o = 1 and the transmitter is idle.
- R11: While the engine owns the port, irq_o is 0 whatever the enables and FIFO states are.
- R12: With both interrupt enables at 0, irq_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | ADDR_W | Host register address |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Host read data, valid the cycle after the read strobe |
| tx_full_i | input | 1 | UART transmit FIFO full |
| tx_empty_i | input | 1 | UART transmit FIFO empty |
| tx_busy_i | input | 1 | UART shifter sending a byte |
| tx_push_o | output | 1 | Push one byte into the transmit FIFO |
| tx_byte_o | output | DATA_W | Byte to push |
| rx_empty_i | input | 1 | UART receive FIFO empty |
| rx_half_i | input | 1 | UART receive FIFO at or above half full |
| rx_byte_i | input | DATA_W | Head of the receive FIFO |
| rx_pop_o | output | 1 | Pop one byte from the receive FIFO |
| eng_tx_valid_i | input | 1 | Engine offers a byte to send |
| eng_tx_byte_i | input | DATA_W | Engine byte to send |
| eng_tx_ready_o | output | 1 | Engine byte accepted this cycle |
| eng_rx_ready_i | input | 1 | Engine takes a received byte |
| eng_rx_valid_o | output | 1 | Received byte available to the engine |
| eng_rx_byte_o | output | DATA_W | Received byte for the engine |
| owner_eng_o | output | 1 | 1 while the engine owns the port |
| flow_en_o | output | 1 | Hardware flow control enabled |
| rx_ie_o | output | 1 | Receive interrupt enable |
| tx_ie_o | output | 1 | Transmit interrupt enable |
| rts_o | output | 1 | Request-to-send level toward the line |
| irq_o | output | 1 | Host interrupt, level |

## Verification
The assertions assume that the UART status inputs are coherent: tx_full_i and tx_empty_i are never both high, and rx_byte_i is meaningful only while rx_empty_i is 0. They also assume that host strobes are single-cycle pulses that are never issued together. The bench drives every input at the falling edge from small tasks that assert one strobe at a time. It sets FIFO flags only in consistent combinations, and it moves tx_busy_i and tx_empty_i on purpose to hold a handover back and then let it through.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int unsigned BIT_RTS    = 0;
  localparam int unsigned BIT_RXIE   = 1;
  localparam int unsigned BIT_TXIE   = 2;
  localparam int unsigned BIT_FLOW   = 5;
  localparam int unsigned BIT_OWN_RO = 6;
  localparam int unsigned BIT_REQ    = 7;
  localparam int unsigned CFG_MIN_W  = BIT_REQ + 1;

  typedef struct packed {
    logic req;
    logic flow;
    logic tx_ie;
    logic rx_ie;
    logic rts;
  } cfg_t;
endpackage

// File: rtl/sport_cfg_reg.sv
module sport_cfg_reg
  import sport_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t              cfg_o
);
  cfg_t cfg_q;
  logic unused_wbits;

  assign unused_wbits = ^{wdata_i[BIT_OWN_RO], wdata_i[4:3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      cfg_q.req   <= wdata_i[BIT_REQ];
      cfg_q.flow  <= wdata_i[BIT_FLOW];
      cfg_q.tx_ie <= wdata_i[BIT_TXIE];
      cfg_q.rx_ie <= wdata_i[BIT_RXIE];
      cfg_q.rts   <= wdata_i[BIT_RTS];
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/sport_owner_arb.sv
module sport_owner_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic tx_idle_i,
  output logic owner_eng_o
);
  logic owner_q;

  // switch only between bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            owner_q <= 1'b0;
    else if ((req_i != owner_q) && tx_idle_i) owner_q <= req_i;
  end

  assign owner_eng_o = owner_q;
endmodule

// File: rtl/sport_path_mux.sv
module sport_path_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              owner_eng_i,
  input  logic              host_push_i,
  input  logic              host_pop_i,
  input  logic [DATA_W-1:0] host_byte_i,
  input  logic              tx_full_i,
  input  logic              rx_empty_i,
  input  logic              eng_tx_valid_i,
  input  logic [DATA_W-1:0] eng_tx_byte_i,
  input  logic              eng_rx_ready_i,
  output logic              eng_tx_ready_o,
  output logic              eng_rx_valid_o,
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              rx_pop_o
);
  always_comb begin
    eng_tx_ready_o = owner_eng_i & ~tx_full_i;
    eng_rx_valid_o = owner_eng_i & ~rx_empty_i;
    if (owner_eng_i) begin
      tx_push_o = eng_tx_valid_i & eng_tx_ready_o;
      tx_byte_o = eng_tx_byte_i;
      rx_pop_o  = eng_rx_valid_o & eng_rx_ready_i;
    end else begin
      tx_push_o = host_push_i & ~tx_full_i;
      tx_byte_o = host_byte_i;
      rx_pop_o  = host_pop_i & ~rx_empty_i;
    end
  end
endmodule

// File: rtl/sport_irq_gen.sv
module sport_irq_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic owner_eng_i,
  input  logic rx_ie_i,
  input  logic tx_ie_i,
  input  logic rx_empty_i,
  input  logic tx_idle_i,
  output logic irq_o
);
  logic irq_q;
  logic src_rx;
  logic src_tx;

  assign src_rx = rx_ie_i & ~rx_empty_i;
  assign src_tx = tx_ie_i & tx_idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= ~owner_eng_i & (src_rx | src_tx);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/sport_owner_ctrl.sv
module sport_owner_ctrl
  import sport_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h08,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h0A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              tx_full_i,
  input  logic              tx_empty_i,
  input  logic              tx_busy_i,
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_byte_o,
  input  logic              rx_empty_i,
  input  logic              rx_half_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              rx_pop_o,
  input  logic              eng_tx_valid_i,
  input  logic [DATA_W-1:0] eng_tx_byte_i,
  output logic              eng_tx_ready_o,
  input  logic              eng_rx_ready_i,
  output logic              eng_rx_valid_o,
  output logic [DATA_W-1:0] eng_rx_byte_o,
  output logic              owner_eng_o,
  output logic              flow_en_o,
  output logic              rx_ie_o,
  output logic              tx_ie_o,
  output logic              rts_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - CFG_MIN_W;

  cfg_t        cfg;
  logic        owner_eng;
  logic        tx_idle;
  logic        sel_cfg, sel_data;
  logic        cfg_wr, data_wr, data_rd;
  logic [DATA_W-1:0] cfg_rd_val;
  logic [DATA_W-1:0] rdata_q;

  assign sel_cfg  = (host_addr_i == CFG_ADDR);
  assign sel_data = (host_addr_i == DATA_ADDR);
  assign cfg_wr   = host_wr_i & sel_cfg;
  assign data_wr  = host_wr_i & sel_data & ~owner_eng;
  assign data_rd  = host_rd_i & sel_data & ~owner_eng;
  assign tx_idle  = tx_empty_i & ~tx_busy_i;

  sport_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (cfg_wr),
    .wdata_i (host_wdata_i),
    .cfg_o   (cfg)
  );

  sport_owner_arb u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (cfg.req),
    .tx_idle_i   (tx_idle),
    .owner_eng_o (owner_eng)
  );

  sport_path_mux #(.DATA_W(DATA_W)) u_mux (
    .owner_eng_i    (owner_eng),
    .host_push_i    (data_wr),
    .host_pop_i     (data_rd),
    .host_byte_i    (host_wdata_i),
    .tx_full_i      (tx_full_i),
    .rx_empty_i     (rx_empty_i),
    .eng_tx_valid_i (eng_tx_valid_i),
    .eng_tx_byte_i  (eng_tx_byte_i),
    .eng_rx_ready_i (eng_rx_ready_i),
    .eng_tx_ready_o (eng_tx_ready_o),
    .eng_rx_valid_o (eng_rx_valid_o),
    .tx_push_o      (tx_push_o),
    .tx_byte_o      (tx_byte_o),
    .rx_pop_o       (rx_pop_o)
  );

  sport_irq_gen u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .owner_eng_i (owner_eng),
    .rx_ie_i     (cfg.rx_ie),
    .tx_ie_i     (cfg.tx_ie),
    .rx_empty_i  (rx_empty_i),
    .tx_idle_i   (tx_idle),
    .irq_o       (irq_o)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign cfg_rd_val = {{PAD_W{1'b0}}, cfg.req, owner_eng, cfg.flow,
                           2'b00, cfg.tx_ie, cfg.rx_ie, cfg.rts};
    end else begin : g_nopad
      assign cfg_rd_val = {cfg.req, owner_eng, cfg.flow,
                           2'b00, cfg.tx_ie, cfg.rx_ie, cfg.rts};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (host_rd_i) begin
      if (sel_cfg)                    rdata_q <= cfg_rd_val;
      else if (data_rd && !rx_empty_i) rdata_q <= rx_byte_i;
      else                            rdata_q <= '0;
    end
  end

  assign host_rdata_o  = rdata_q;
  assign eng_rx_byte_o = rx_byte_i;
  assign owner_eng_o   = owner_eng;
  assign flow_en_o     = cfg.flow;
  assign rx_ie_o       = cfg.rx_ie;
  assign tx_ie_o       = cfg.tx_ie;
  assign rts_o         = cfg.flow ? ~rx_half_i : cfg.rts;
endmodule

// File: rtl/sport_owner_chk.sv
module sport_owner_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h0A
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_wr_i,
  input logic              host_rd_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic              tx_full_i,
  input logic              tx_empty_i,
  input logic              tx_busy_i,
  input logic              tx_push_o,
  input logic              rx_empty_i,
  input logic              rx_pop_o,
  input logic              eng_tx_valid_i,
  input logic              eng_rx_ready_i,
  input logic              eng_tx_ready_o,
  input logic              eng_rx_valid_o,
  input logic              owner_eng_o,
  input logic              rx_ie_o,
  input logic              irq_o
);
  p_no_push_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_i |-> !tx_push_o);

  p_no_pop_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_i |-> !rx_pop_o);

  p_switch_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_eng_o != $past(owner_eng_o)) |-> $past(tx_empty_i && !tx_busy_i));

  p_host_hides_eng_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !owner_eng_o |-> (!eng_tx_ready_o && !eng_rx_valid_o));

  p_host_write_dropped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_eng_o && host_wr_i && host_addr_i == DATA_ADDR && !eng_tx_valid_i)
      |-> !tx_push_o);

  p_host_read_dropped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_eng_o && host_rd_i && host_addr_i == DATA_ADDR && !eng_rx_ready_i)
      |-> !rx_pop_o);

  p_rx_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!owner_eng_o && rx_ie_o && !rx_empty_i) |=> irq_o);

  p_irq_masked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_eng_o && $past(owner_eng_o)) |-> !irq_o);
endmodule

bind sport_owner_ctrl sport_owner_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_ADDR (DATA_ADDR)
) u_chk (.*);

// File: tb/sport_owner_ctrl_test.sv
module sport_owner_ctrl_test;
  localparam logic [7:0] A_CFG  = 8'h08;
  localparam logic [7:0] A_DATA = 8'h0A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hwr = 0, hrd = 0;
  logic [7:0] haddr = 0, hwdata = 0, hrdata;
  logic       tx_full = 0, tx_empty = 1, tx_busy = 0, tx_push;
  logic [7:0] tx_byte;
  logic       rx_empty = 1, rx_half = 0, rx_pop;
  logic [7:0] rx_byte = 8'h00;
  logic       e_tx_valid = 0, e_rx_ready = 0, e_tx_ready, e_rx_valid;
  logic [7:0] e_tx_byte = 0, e_rx_byte;
  logic       owner, flow, rxie, txie, rts, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sport_owner_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(hwr), .host_rd_i(hrd), .host_addr_i(haddr),
    .host_wdata_i(hwdata), .host_rdata_o(hrdata),
    .tx_full_i(tx_full), .tx_empty_i(tx_empty), .tx_busy_i(tx_busy),
    .tx_push_o(tx_push), .tx_byte_o(tx_byte),
    .rx_empty_i(rx_empty), .rx_half_i(rx_half), .rx_byte_i(rx_byte),
    .rx_pop_o(rx_pop),
    .eng_tx_valid_i(e_tx_valid), .eng_tx_byte_i(e_tx_byte),
    .eng_tx_ready_o(e_tx_ready), .eng_rx_ready_i(e_rx_ready),
    .eng_rx_valid_o(e_rx_valid), .eng_rx_byte_o(e_rx_byte),
    .owner_eng_o(owner), .flow_en_o(flow), .rx_ie_o(rxie), .tx_ie_o(txie),
    .rts_o(rts), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    haddr = a; hwdata = d; hwr = 1;
    @(negedge clk);
    hwr = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    haddr = a; hrd = 1;
    @(negedge clk);
    hrd = 0;
  endtask

  // {write value, expected readback}; bit 7 kept 0, owner stays host
  localparam logic [15:0] CFG_VEC [6] = '{
    16'h0000, 16'h0101, 16'h5E06, 16'h7F27, 16'h2121, 16'h3820
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 owner", owner, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rts", rts, 0);
    chk("R1 fields", {flow, rxie, txie}, 0);

    for (int i = 0; i < 6; i++) begin
      wr(A_CFG, CFG_VEC[i][15:8]);
      rd(A_CFG);
      chk("R2 readback", hrdata, {24'd0, CFG_VEC[i][7:0]});
      chk("R3 rts", rts, CFG_VEC[i][5] ? 1 : CFG_VEC[i][0]);
    end

    // R3 flow on, half full
    wr(A_CFG, 8'h20);
    rx_half = 1; #1;
    chk("R3 rts half", rts, 0);
    rx_half = 0;
    @(negedge clk);

    // R12 no enables, sources active
    wr(A_CFG, 8'h00);
    rx_empty = 0; rx_byte = 8'hC3;
    @(negedge clk);
    chk("R12 irq", irq, 0);

    // R4 host transmit
    haddr = A_DATA; hwdata = 8'h5A; hwr = 1; #1;
    chk("R4 push", tx_push, 1);
    chk("R4 byte", tx_byte, 8'h5A);
    tx_full = 1; #1;
    chk("R4 full no push", tx_push, 0);
    @(negedge clk);
    hwr = 0; tx_full = 0;

    // R5 host receive
    haddr = A_DATA; hrd = 1; #1;
    chk("R5 pop", rx_pop, 1);
    @(negedge clk);
    hrd = 0;
    chk("R5 data", hrdata, 8'hC3);
    rx_empty = 1;
    haddr = A_DATA; hrd = 1; #1;
    chk("R5 empty no pop", rx_pop, 0);
    @(negedge clk);
    hrd = 0;
    chk("R5 empty data", hrdata, 0);

    // R9 receive interrupt
    wr(A_CFG, 8'h02);
    rx_empty = 0;
    @(negedge clk);
    chk("R9 irq set", irq, 1);
    @(negedge clk);
    chk("R9 irq held", irq, 1);
    rx_empty = 1;
    @(negedge clk);
    chk("R9 irq clear", irq, 0);

    // R10 transmit interrupt
    tx_busy = 1;
    wr(A_CFG, 8'h04);
    @(negedge clk);
    chk("R10 busy", irq, 0);
    tx_busy = 0;
    @(negedge clk);
    chk("R10 idle", irq, 1);

    // R6 handover waits for idle transmitter
    tx_busy = 1;
    wr(A_CFG, 8'h86);
    repeat (3) @(negedge clk);
    chk("R6 held", owner, 0);
    tx_busy = 0;
    @(negedge clk);
    chk("R6 taken", owner, 1);
    rd(A_CFG);
    chk("R2 owner bit", hrdata, 8'hC6);

    // R11 masked with both sources active
    rx_empty = 0; rx_byte = 8'h3C;
    @(negedge clk);
    chk("R11 irq", irq, 0);

    // R7 engine routing
    e_tx_valid = 1; e_tx_byte = 8'hA5; e_rx_ready = 1; #1;
    chk("R7 push", tx_push, 1);
    chk("R7 byte", tx_byte, 8'hA5);
    chk("R7 rx valid", e_rx_valid, 1);
    chk("R7 rx pop", rx_pop, 1);
    chk("R7 rx byte", e_rx_byte, 8'h3C);
    tx_full = 1; #1;
    chk("R7 ready full", e_tx_ready, 0);
    @(negedge clk);
    tx_full = 0; e_tx_valid = 0; e_rx_ready = 0;

    // R8 host data access ignored
    haddr = A_DATA; hwdata = 8'h77; hwr = 1; #1;
    chk("R8 write dropped", tx_push, 0);
    @(negedge clk);
    hwr = 0;
    haddr = A_DATA; hrd = 1; #1;
    chk("R8 read no pop", rx_pop, 0);
    @(negedge clk);
    hrd = 0;
    chk("R8 read zero", hrdata, 0);

    // R6 hand back to host
    rx_empty = 1;
    wr(A_CFG, 8'h06);
    @(negedge clk);
    chk("R6 back", owner, 0);
    #1;
    chk("R7 host hides", {e_tx_ready, e_rx_valid}, 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule